// File: doc/BRIEF.md
# Audio Sample-Rate Strobe Generator

This block turns one of several master clock sources into a single-cycle sample strobe for an audio transfer path. It runs entirely in the fastest clock domain and treats every master source as a clock-enable tick. The three tick inputs are a 25.175 MHz internal source, an external source and a 32 MHz internal source. A 2-bit select picks which one drives the divider chain.

In prescaled mode the chosen source passes through two divider stages. The first stage divides by a fixed 256. The second divides by one more than a stored 4-bit prescale value. When the stored prescale value is zero, the block falls back to a legacy mode. A 2-bit rate code then picks one of three fixed rates, all derived from the 25.175 MHz source, or it picks mute. Any change to the configuration restarts the dividers, so the first strobe after a change always comes a full new period later.

Top module: `audio_rate_gen`

## Requirements
- R1: In prescaled mode (stored prescale value N from 1 to 15), a strobe appears in the cycle after the 256*(N+1)-th tick of the selected source, counted since the last restart, and again after every further 256*(N+1) ticks.
- R2: With select 00 and N=1, the strobe comes every 512 ticks (about 49.17 kHz from 25.175 MHz). With N=2 it comes every 768 ticks (about 32.78 kHz).
- R3: A prescale write carries a full byte, but only bits 3:0 are stored and bits 7:4 have no effect. `legacyMode` is 1 exactly when the stored value is 0, and it shows the new value in the cycle after the write.
- R4: In legacy mode, rate codes 01, 10 and 11 give a strobe every 2011, 1006 and 503 ticks of `tickInt25` (about 12.5, 25 and 50 kHz). This holds whatever the source select is.
- R5: In legacy mode, rate code 00 drives `muteFlag` to 1 and produces no strobes.
- R6: In prescaled mode, select 00 counts `tickInt25`, 01 counts `tickExt` and 10 counts `tickInt32`. Ticks on the sources that are not selected have no effect.
- R7: In prescaled mode, select 11 counts nothing, so no strobes are produced.
- R8: A change in the stored prescale value, the source select or the rate code restarts all counters. A tick in the same cycle as the change is not counted.
- R9: After reset the stored prescale value is 1, `sampleStrobe` is 0, `legacyMode` is 0 and `muteFlag` is 0.
- R10: `sampleStrobe` is never high in two consecutive cycles. It is only high in the cycle after a tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock; all logic runs on it |
| rst_n | input | 1 | Active-low synchronous reset |
| tickInt25 | input | 1 | Enable tick of the 25.175 MHz internal source |
| tickExt | input | 1 | Enable tick of the external source |
| tickInt32 | input | 1 | Enable tick of the 32 MHz internal source |
| srcSel | input | 2 | Source select: 00 int25, 01 ext, 10 int32, 11 none |
| prescaleWe | input | 1 | Write strobe for the prescale byte |
| prescaleData | input | 8 | Prescale byte; only bits 3:0 are kept |
| legacyRate | input | 2 | Legacy rate code: 00 mute, 01 ~12.5k, 10 ~25k, 11 ~50k |
| sampleStrobe | output | 1 | One-cycle sample strobe |
| legacyMode | output | 1 | 1 when the stored prescale value is 0 |
| muteFlag | output | 1 | 1 in legacy mode with rate code 00 |

## Verification
The divider state is visible only through the timing of `sampleStrobe`. A wrong stage counter or a missed restart therefore shows as a strobe that comes early, late or twice. With the sources ticking every cycle, such an error appears within one period: at most 4096 cycles in prescaled mode and 2011 cycles in legacy mode. A wrong stored nibble or a wrong rate-code register shows up in the very next cycle on `legacyMode` or `muteFlag`. A cycle-accurate reference in the bench compares all three outputs on every cycle, under random tick densities and random configurations.

// File: rtl/audio_rate_gen_pkg.sv
package audio_rate_gen_pkg;
  // width of the stored prescale value
  localparam int PS_W = 4;
  // fixed first-stage divide is 2**PRE_W
  localparam int PRE_W = 8;
  // legacy periods in ticks of the 25.175 MHz source
  localparam int LEG_PERIOD_SLOW = 2011;
  localparam int LEG_PERIOD_MID  = 1006;
  localparam int LEG_PERIOD_FAST = 503;
  localparam int LEG_W = $clog2(LEG_PERIOD_SLOW + 1);

  typedef struct packed {
    logic             srcTick;   // counted tick this cycle
    logic             clrCnt;    // restart all counters
    logic             legacyOn;  // legacy divider in use
    logic [PS_W-1:0]  divN;      // second-stage terminal value
    logic [LEG_W-1:0] legLast;   // legacy terminal count
  } ctrl_t;

  function automatic logic [LEG_W-1:0] legacyLast(input logic [1:0] code);
    case (code)
      2'b01:   legacyLast = LEG_W'(LEG_PERIOD_SLOW - 1);
      2'b10:   legacyLast = LEG_W'(LEG_PERIOD_MID - 1);
      2'b11:   legacyLast = LEG_W'(LEG_PERIOD_FAST - 1);
      default: legacyLast = '0;
    endcase
  endfunction
endpackage

// File: rtl/audio_rate_gen_ctrl.sv
module audio_rate_gen_ctrl
  import audio_rate_gen_pkg::*;
#(
  parameter logic [PS_W-1:0] RESET_PRESCALE = PS_W'(1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tickInt25,
  input  logic            tickExt,
  input  logic            tickInt32,
  input  logic [1:0]      srcSel,
  input  logic            prescaleWe,
  input  logic [PS_W-1:0] prescaleNib,
  input  logic [1:0]      legacyRate,
  output ctrl_t           ctrl,
  output logic            legacyMode,
  output logic            muteFlag
);
  logic [PS_W-1:0] psQ;
  logic [1:0]      srcQ;
  logic [1:0]      rateQ;
  logic            psChange;
  logic            cfgChange;
  logic            isLegacy;
  logic            selTick;

  assign psChange  = prescaleWe && (prescaleNib != psQ);
  assign cfgChange = psChange || (srcSel != srcQ) || (legacyRate != rateQ);
  assign isLegacy  = (psQ == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      psQ   <= RESET_PRESCALE;
      srcQ  <= 2'b00;
      rateQ <= 2'b00;
    end else begin
      if (prescaleWe) psQ <= prescaleNib;
      srcQ  <= srcSel;
      rateQ <= legacyRate;
    end
  end

  // tick routing: legacy always runs from the 25.175 MHz source
  always_comb begin
    if (isLegacy) begin
      selTick = tickInt25 && (rateQ != 2'b00);
    end else begin
      case (srcQ)
        2'b00:   selTick = tickInt25;
        2'b01:   selTick = tickExt;
        2'b10:   selTick = tickInt32;
        default: selTick = 1'b0;
      endcase
    end
  end

  always_comb begin
    ctrl.srcTick  = selTick;
    ctrl.clrCnt   = cfgChange;
    ctrl.legacyOn = isLegacy;
    ctrl.divN     = psQ;
    ctrl.legLast  = legacyLast(rateQ);
  end

  assign legacyMode = isLegacy;
  assign muteFlag   = isLegacy && (rateQ == 2'b00);
endmodule

// File: rtl/audio_rate_gen_dp.sv
module audio_rate_gen_dp
  import audio_rate_gen_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  ctrl_t ctrl,
  output logic  sampleStrobe
);
  logic [PRE_W-1:0] preCnt;
  logic [PS_W-1:0]  divCnt;
  logic [LEG_W-1:0] legCnt;
  logic             preCarry;
  logic             divDone;
  logic             legDone;

  assign preCarry = ctrl.srcTick && !ctrl.legacyOn && (preCnt == '1);
  assign divDone  = preCarry && (divCnt == ctrl.divN);
  assign legDone  = ctrl.srcTick && ctrl.legacyOn && (legCnt == ctrl.legLast);

  always_ff @(posedge clk) begin
    if (!rst_n || ctrl.clrCnt) begin
      preCnt       <= '0;
      divCnt       <= '0;
      legCnt       <= '0;
      sampleStrobe <= 1'b0;
    end else begin
      sampleStrobe <= divDone || legDone;
      if (ctrl.srcTick && !ctrl.legacyOn) begin
        preCnt <= preCnt + PRE_W'(1);
        if (preCarry) divCnt <= divDone ? '0 : divCnt + PS_W'(1);
      end
      if (ctrl.srcTick && ctrl.legacyOn) begin
        legCnt <= legDone ? '0 : legCnt + LEG_W'(1);
      end
    end
  end
endmodule

// File: rtl/audio_rate_gen.sv
module audio_rate_gen
  import audio_rate_gen_pkg::*;
#(
  parameter logic [PS_W-1:0] RESET_PRESCALE = PS_W'(1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tickInt25,
  input  logic       tickExt,
  input  logic       tickInt32,
  input  logic [1:0] srcSel,
  input  logic       prescaleWe,
  input  logic [7:0] prescaleData,
  input  logic [1:0] legacyRate,
  output logic       sampleStrobe,
  output logic       legacyMode,
  output logic       muteFlag
);
  ctrl_t ctrlBus;
  logic  unusedHiNibble;

  // the upper nibble of the prescale byte is dropped on purpose
  assign unusedHiNibble = ^prescaleData[7:PS_W];

  audio_rate_gen_ctrl #(.RESET_PRESCALE(RESET_PRESCALE)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .tickInt25  (tickInt25),
    .tickExt    (tickExt),
    .tickInt32  (tickInt32),
    .srcSel     (srcSel),
    .prescaleWe (prescaleWe),
    .prescaleNib(prescaleData[PS_W-1:0]),
    .legacyRate (legacyRate),
    .ctrl       (ctrlBus),
    .legacyMode (legacyMode),
    .muteFlag   (muteFlag)
  );

  audio_rate_gen_dp u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl        (ctrlBus),
    .sampleStrobe(sampleStrobe)
  );
endmodule

// File: rtl/audio_rate_gen_chk.sv
module audio_rate_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tickInt25,
  input logic       tickExt,
  input logic       tickInt32,
  input logic [1:0] srcSel,
  input logic       prescaleWe,
  input logic [7:0] prescaleData,
  input logic [1:0] legacyRate,
  input logic       sampleStrobe,
  input logic       legacyMode,
  input logic       muteFlag
);
  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sampleStrobe |=> !sampleStrobe);

  assert_needs_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sampleStrobe |-> $past(tickInt25 || tickExt || tickInt32));

  assert_mute_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    muteFlag |-> !sampleStrobe);

  assert_nibble_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    prescaleWe |=> (legacyMode == ($past(prescaleData[3:0]) == 4'd0)));

  assert_no_clock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (srcSel == 2'b11 && !legacyMode && !prescaleWe) |=> !sampleStrobe);
endmodule

bind audio_rate_gen audio_rate_gen_chk u_chk (.*);

// File: tb/audio_rate_gen_tb.sv
module audio_rate_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tickInt25 = 1'b0, tickExt = 1'b0, tickInt32 = 1'b0;
  logic [1:0] srcSel = 2'b00;
  logic       prescaleWe = 1'b0;
  logic [7:0] prescaleData = 8'h00;
  logic [1:0] legacyRate = 2'b00;
  logic       sampleStrobe, legacyMode, muteFlag;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  // reference state
  logic [3:0] mPs = 4'd1;
  logic [1:0] mSrc = 2'b00, mRate = 2'b00;
  int         mCnt = 0;
  logic       mStrobe = 1'b0;
  logic       prevStrobe = 1'b0;
  int         strobeSeen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_rate_gen u_dut (
    .clk(clk), .rst_n(rst_n), .tickInt25(tickInt25), .tickExt(tickExt),
    .tickInt32(tickInt32), .srcSel(srcSel), .prescaleWe(prescaleWe),
    .prescaleData(prescaleData), .legacyRate(legacyRate),
    .sampleStrobe(sampleStrobe), .legacyMode(legacyMode), .muteFlag(muteFlag)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int legPeriod(input logic [1:0] r);
    case (r)
      2'b01:   return 2011;
      2'b10:   return 1006;
      default: return 503;
    endcase
  endfunction

  function automatic string modeTag();
    if (mPs == 4'd0) return (mRate == 2'b00) ? "R5" : "R4";
    return (mSrc == 2'b11) ? "R7" : "R1";
  endfunction

  // one cycle: drive at negedge, update reference, compare at next negedge
  task automatic cyc(input logic we, input logic [7:0] d, input logic t25,
                     input logic tE, input logic t32);
    logic [3:0] newPs;
    logic       chg, leg, tk, act;
    int         per;
    prescaleWe = we; prescaleData = d;
    tickInt25 = t25; tickExt = tE; tickInt32 = t32;
    newPs = we ? d[3:0] : mPs;
    chg = (we && d[3:0] != mPs) || (srcSel != mSrc) || (legacyRate != mRate);
    leg = (newPs == 4'd0);
    if (leg) begin
      tk = t25; act = (legacyRate != 2'b00); per = legPeriod(legacyRate);
    end else begin
      case (srcSel)
        2'b00: tk = t25;
        2'b01: tk = tE;
        2'b10: tk = t32;
        default: tk = 1'b0;
      endcase
      act = (srcSel != 2'b11); per = 256 * (int'(newPs) + 1);
    end
    mStrobe = 1'b0;
    if (chg) mCnt = 0;
    else if (act && tk) begin
      if (mCnt == per - 1) begin mCnt = 0; mStrobe = 1'b1; end
      else mCnt++;
    end
    mPs = newPs; mSrc = srcSel; mRate = legacyRate;
    @(posedge clk);
    @(negedge clk);
    check(sampleStrobe === mStrobe, {modeTag(), " R8 strobe"}, int'(sampleStrobe), int'(mStrobe));
    check(legacyMode === (mPs == 4'd0) && muteFlag === (mPs == 4'd0 && mRate == 2'b00),
          "R3 R5 flags", {legacyMode, muteFlag}, {(mPs == 4'd0), (mPs == 4'd0 && mRate == 2'b00)});
    if (sampleStrobe) begin
      strobeSeen++;
      check(!prevStrobe, "R10 pulse width", 2, 1);
    end
    prevStrobe = sampleStrobe;
  endtask

  // run n cycles with ticks on the sources in mask, each with probability 1/dens
  task automatic runTicks(input int n, input int dens, input logic [2:0] mask);
    for (int i = 0; i < n; i++) begin
      cyc(1'b0, 8'h00,
          mask[0] && ($urandom % dens == 0),
          mask[1] && ($urandom % dens == 0),
          mask[2] && ($urandom % dens == 0));
    end
  endtask

  // apply a configuration (write in the first cycle), then run
  task automatic phase(input logic [7:0] ps, input logic [1:0] s, input logic [1:0] r,
                       input int n, input int dens, input logic [2:0] mask);
    srcSel = s; legacyRate = r;
    cyc(1'b1, ps, mask[0], mask[1], mask[2]);
    strobeSeen = 0;
    runTicks(n - 1, dens, mask);
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(sampleStrobe === 1'b0, "R9 strobe", int'(sampleStrobe), 0);
    check(legacyMode === 1'b0, "R9 legacyMode", int'(legacyMode), 0);
    check(muteFlag === 1'b0, "R9 muteFlag", int'(muteFlag), 0);

    // R2: N=1 -> 512, N=2 -> 768 ticks
    phase(8'h01, 2'b00, 2'b01, 2058, 1, 3'b111);
    check(strobeSeen == 4, "R2 N=1 count", strobeSeen, 4);
    phase(8'h02, 2'b00, 2'b01, 2058, 1, 3'b111);
    check(strobeSeen == 2, "R2 N=2 count", strobeSeen, 2);

    // R3: upper nibble ignored
    phase(8'hF0, 2'b00, 2'b11, 20, 1, 3'b111);
    check(legacyMode === 1'b1, "R3 F0 -> legacy", int'(legacyMode), 1);
    phase(8'hA5, 2'b00, 2'b11, 1537, 1, 3'b111);
    check(legacyMode === 1'b0, "R3 A5 -> prescaled", int'(legacyMode), 0);
    check(strobeSeen == 1, "R3 A5 period 1536", strobeSeen, 1);

    // R4 legacy rates
    phase(8'h00, 2'b10, 2'b11, 2013, 1, 3'b111);
    check(strobeSeen == 4, "R4 code 11 count", strobeSeen, 4);
    phase(8'h00, 2'b01, 2'b01, 2013, 1, 3'b111);
    check(strobeSeen == 1, "R4 code 01 count", strobeSeen, 1);

    // R5 mute
    phase(8'h00, 2'b00, 2'b00, 3000, 1, 3'b111);
    check(strobeSeen == 0, "R5 mute strobes", strobeSeen, 0);
    check(muteFlag === 1'b1, "R5 muteFlag", int'(muteFlag), 1);

    // R7 no clock
    phase(8'h01, 2'b11, 2'b01, 3000, 1, 3'b111);
    check(strobeSeen == 0, "R7 select 11", strobeSeen, 0);

    // R6 source routing
    phase(8'h01, 2'b01, 2'b01, 600, 1, 3'b010);
    check(strobeSeen == 1, "R6 ext selected", strobeSeen, 1);
    phase(8'h01, 2'b00, 2'b01, 600, 1, 3'b110);
    check(strobeSeen == 0, "R6 unselected ticks", strobeSeen, 0);

    // R8 restart on select change mid-period
    phase(8'h03, 2'b00, 2'b01, 900, 1, 3'b111);
    phase(8'h03, 2'b10, 2'b01, 1024, 1, 3'b111);
    check(strobeSeen == 0, "R8 no early strobe", strobeSeen, 0);
    runTicks(1, 1, 3'b111);
    check(strobeSeen == 1, "R8 full new period", strobeSeen, 1);

    // random configurations and tick densities (R1 and all modes)
    for (int p = 0; p < 20; p++) begin
      phase(8'($urandom), 2'($urandom), 2'($urandom), 4500,
            1 + int'($urandom % 3), 3'b111);
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule